// File: doc/BRIEF.md
# Serial Overhead Gated Clock Generator

This block exchanges SONET overhead bytes with an external device over a three-wire serial link made of a gated clock, a transmit data line and a receive data line. Time is divided into frame periods of 243 serial clock cycles. In each period the clock is held low for a gap, and the gap marks the frame to the far end. One or two bursts of clock pulses follow the gap. In every clocked cycle one overhead bit goes out and one bit is taken in.

A two-bit mode input picks the overhead set. It can be the whole STS-1 overhead (27 bytes), the lower data communication bytes (3), the upper data communication bytes (9), or both data communication groups (12 bytes in two bursts). The block runs from a base clock at twice the serial rate. Each serial cycle is one base cycle low followed by one base cycle high. The transmit byte for each slot is taken from a parallel input at the moment its first bit goes out, and an index output names the slot to be fetched next. Each received byte is presented with a one-cycle strobe and its slot index. A frame-start input restarts the pattern at any time.

Top module: `ohb_serial_gate`

## Requirements
- R1: A frame period is 243 serial cycles, and each serial cycle is 2 base clock cycles. Without a frame-start pulse the pattern repeats every 486 base cycles. Counting base cycles from frame start as t = 2c + h (c = serial cycle, h = half), the clock can be high only at odd t.
- R2: With mode_i = 2'b00 (all STS-1 overhead), serial cycles 0..26 have no clock pulse and cycles 27..242 each carry one pulse, so the first rise comes at t = 55 and a frame has 216 pulses.
- R3: With mode_i = 2'b01 (lower data bytes), cycles 0..218 are idle and cycles 219..242 carry pulses: the first rise comes at t = 439 and a frame has 24 pulses.
- R4: With mode_i = 2'b10 (upper data bytes), cycles 0..170 are idle and cycles 171..242 carry pulses: the first rise comes at t = 343 and a frame has 72 pulses.
- R5: With mode_i = 2'b11 (both groups), the frame is 99 idle cycles, 24 pulses (cycles 99..122), 48 idle cycles (123..170) and 72 pulses (171..242). The first rise comes at t = 199 and a frame has 96 pulses.
- R6: sck_o is low in the first half of every serial cycle and in all idle cycles. It is high for exactly one base cycle, the second half, in each clocked cycle.
- R7: tx_o sends each byte most significant bit first and changes only at the start of a serial cycle, never while sck_o is high. A byte is taken from tx_byte_i when its first bit is sent, and tx_idx_o then advances. tx_idx_o is the 0-based slot index within the frame for the current mode (0..11 running across both bursts in mode 2'b11) and is 0 at frame start.
- R8: rx_i is sampled when sck_o rises, most significant bit first. On the 8th sample of a byte, byte_vld_o is high for one base cycle, with rx_byte_o holding the byte and byte_idx_o its 0-based slot index.
- R9: A frame-start pulse on fs_i at any point restarts the frame: the next base cycle is t = 0, partial bytes are dropped, and the slot indices go back to 0.
- R10: While reset is held, sck_o, tx_o and byte_vld_o are 0, and tx_idx_o and byte_idx_o are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Base clock, twice the serial clock rate |
| rst_n | input | 1 | Active-low reset |
| fs_i | input | 1 | Frame-start pulse, restarts the frame pattern |
| mode_i | input | 2 | Overhead set: 00 all, 01 lower data, 10 upper data, 11 both groups |
| tx_byte_i | input | 8 | Transmit byte for slot tx_idx_o |
| rx_i | input | 1 | Serial receive data from the far end |
| sck_o | output | 1 | Gated serial clock |
| tx_o | output | 1 | Serial transmit data |
| tx_idx_o | output | 5 | Slot index of the next transmit byte to be fetched |
| rx_byte_o | output | 8 | Last received byte |
| byte_vld_o | output | 1 | One-cycle strobe for a received byte |
| byte_idx_o | output | 5 | Slot index of rx_byte_o |

## Verification
Each of the four modes runs for at least two whole frames. The clock is compared with the expected gap and burst map in every base cycle. This separates the single-burst gaps of 27, 171 and 219 cycles from the two-burst layout, including its 48-cycle middle gap. The transmit and receive bytes carry patterns that change with slot and mode, so a wrong bit order, a wrong slot index or a missing index reset after a frame wrap shows up as a wrong byte. Frame-start pulses in the middle of a burst, one with a mode change and one without, show that a restart drops the partial byte and places the next gap again from t = 0.

// File: rtl/ohb_pkg.sv
package ohb_pkg;
   typedef enum logic [1:0] {
      OHB_ALL  = 2'b00,
      OHB_DLO  = 2'b01,
      OHB_DHI  = 2'b10,
      OHB_DALL = 2'b11
   } ohb_mode_e;
endpackage

// File: rtl/ohb_frame_timer.sv
module ohb_frame_timer #(
   parameter int FRAME_CYC = 243,
   parameter int CYC_W     = $clog2(FRAME_CYC)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             fs_i,
   output logic [CYC_W-1:0] cyc_nxt_o,
   output logic             ph_nxt_o,
   output logic [CYC_W-1:0] cyc_o
);
   localparam logic [CYC_W-1:0] LAST = CYC_W'(FRAME_CYC - 1);

   logic [CYC_W-1:0] cyc_q;
   logic             ph_q;

   always_comb begin
      if (fs_i) begin
         cyc_nxt_o = '0;
         ph_nxt_o  = 1'b0;
      end else if (!ph_q) begin
         cyc_nxt_o = cyc_q;
         ph_nxt_o  = 1'b1;
      end else if (cyc_q == LAST) begin
         cyc_nxt_o = '0;
         ph_nxt_o  = 1'b0;
      end else begin
         cyc_nxt_o = cyc_q + 1'b1;
         ph_nxt_o  = 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cyc_q <= '0;
         ph_q  <= 1'b0;
      end else begin
         cyc_q <= cyc_nxt_o;
         ph_q  <= ph_nxt_o;
      end
   end

   assign cyc_o = cyc_q;

   a_r1_cyc_bound: assert property (@(posedge clk) disable iff (!rst_n)
      cyc_q < CYC_W'(FRAME_CYC));
   a_r1_wrap: assert property (@(posedge clk) disable iff (!rst_n)
      (!fs_i && ph_q && cyc_q == LAST) |=> (cyc_q == '0 && !ph_q));
   a_r9_restart: assert property (@(posedge clk) disable iff (!rst_n)
      fs_i |=> (cyc_q == '0 && !ph_q));
endmodule

// File: rtl/ohb_burst_window.sv
module ohb_burst_window
   import ohb_pkg::*;
#(
   parameter int CYC_W     = 8,
   parameter int ALL_START = 27,
   parameter int DLO_START = 219,
   parameter int DHI_START = 171,
   parameter int B1_START  = 99,
   parameter int B1_END    = 123
) (
   input  ohb_mode_e        mode_i,
   input  logic [CYC_W-1:0] cyc_i,
   output logic             act_o
);
   always_comb begin
      unique case (mode_i)
         OHB_ALL:  act_o = (cyc_i >= CYC_W'(ALL_START));
         OHB_DLO:  act_o = (cyc_i >= CYC_W'(DLO_START));
         OHB_DHI:  act_o = (cyc_i >= CYC_W'(DHI_START));
         default:  act_o = ((cyc_i >= CYC_W'(B1_START)) && (cyc_i < CYC_W'(B1_END)))
                           || (cyc_i >= CYC_W'(DHI_START));
      endcase
   end
endmodule

// File: rtl/ohb_bit_shifter.sv
module ohb_bit_shifter #(
   parameter int BYTE_BITS = 8,
   parameter int IDX_W     = 5,
   parameter bit MSB_FIRST = 1'b1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 fall_i,
   input  logic                 rise_i,
   input  logic                 act_i,
   input  logic                 clr_i,
   input  logic [BYTE_BITS-1:0] tx_byte_i,
   input  logic                 rx_i,
   output logic                 tx_o,
   output logic [IDX_W-1:0]     tx_idx_o,
   output logic [BYTE_BITS-1:0] rx_byte_o,
   output logic                 byte_vld_o,
   output logic [IDX_W-1:0]     byte_idx_o
);
   localparam int BIT_W = $clog2(BYTE_BITS);
   localparam logic [BIT_W-1:0] BIT_LAST = BIT_W'(BYTE_BITS - 1);

   logic [BYTE_BITS-1:0] tsh_q, rsh_q;
   logic [BIT_W-1:0]     tbit_q, rbit_q;
   logic [IDX_W-1:0]     tidx_q, ridx_q;
   logic                 tx_q;

   logic                 tx_first, tx_next;
   logic [BYTE_BITS-1:0] tx_rest, tx_shift, rx_shift;

   if (MSB_FIRST) begin : g_msb
      assign tx_first = tx_byte_i[BYTE_BITS-1];
      assign tx_rest  = tx_byte_i << 1;
      assign tx_next  = tsh_q[BYTE_BITS-1];
      assign tx_shift = tsh_q << 1;
      assign rx_shift = {rsh_q[BYTE_BITS-2:0], rx_i};
   end else begin : g_lsb
      assign tx_first = tx_byte_i[0];
      assign tx_rest  = tx_byte_i >> 1;
      assign tx_next  = tsh_q[0];
      assign tx_shift = tsh_q >> 1;
      assign rx_shift = {rx_i, rsh_q[BYTE_BITS-1:1]};
   end

   // transmit side: updates at the start of each serial cycle
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tx_q   <= 1'b0;
         tsh_q  <= '0;
         tbit_q <= '0;
         tidx_q <= '0;
      end else if (clr_i) begin
         tx_q   <= 1'b0;
         tbit_q <= '0;
         tidx_q <= '0;
      end else if (fall_i) begin
         if (act_i) begin
            if (tbit_q == '0) begin
               tx_q   <= tx_first;
               tsh_q  <= tx_rest;
               tidx_q <= tidx_q + 1'b1;
            end else begin
               tx_q  <= tx_next;
               tsh_q <= tx_shift;
            end
            tbit_q <= (tbit_q == BIT_LAST) ? '0 : tbit_q + 1'b1;
         end else begin
            tx_q <= 1'b0;
         end
      end
   end

   // receive side: samples when the serial clock rises
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rsh_q      <= '0;
         rbit_q     <= '0;
         ridx_q     <= '0;
         rx_byte_o  <= '0;
         byte_vld_o <= 1'b0;
         byte_idx_o <= '0;
      end else begin
         byte_vld_o <= 1'b0;
         if (clr_i) begin
            rbit_q <= '0;
            ridx_q <= '0;
         end else if (rise_i && act_i) begin
            rsh_q <= rx_shift;
            if (rbit_q == BIT_LAST) begin
               rbit_q     <= '0;
               rx_byte_o  <= rx_shift;
               byte_vld_o <= 1'b1;
               byte_idx_o <= ridx_q;
               ridx_q     <= ridx_q + 1'b1;
            end else begin
               rbit_q <= rbit_q + 1'b1;
            end
         end
      end
   end

   assign tx_o     = tx_q;
   assign tx_idx_o = tidx_q;

   a_r7_tx_hold: assert property (@(posedge clk) disable iff (!rst_n)
      rise_i |=> $stable(tx_q));
   a_r8_vld_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      byte_vld_o |=> !byte_vld_o);
   a_r9_idx_clear: assert property (@(posedge clk) disable iff (!rst_n)
      clr_i |=> (tidx_q == '0 && !byte_vld_o));
endmodule

// File: rtl/ohb_serial_gate.sv
module ohb_serial_gate
   import ohb_pkg::*;
#(
   parameter int FRAME_CYC = 243,
   parameter int BYTE_BITS = 8,
   parameter int ALL_BYTES = 27,
   parameter int DLO_BYTES = 3,
   parameter int DHI_BYTES = 9,
   parameter int MID_GAP   = 48,
   parameter bit MSB_FIRST = 1'b1,
   parameter int IDX_W     = 5
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 fs_i,
   input  logic [1:0]           mode_i,
   input  logic [BYTE_BITS-1:0] tx_byte_i,
   input  logic                 rx_i,
   output logic                 sck_o,
   output logic                 tx_o,
   output logic [IDX_W-1:0]     tx_idx_o,
   output logic [BYTE_BITS-1:0] rx_byte_o,
   output logic                 byte_vld_o,
   output logic [IDX_W-1:0]     byte_idx_o
);
   localparam int CYC_W     = $clog2(FRAME_CYC);
   localparam int ALL_START = FRAME_CYC - ALL_BYTES * BYTE_BITS;
   localparam int DLO_START = FRAME_CYC - DLO_BYTES * BYTE_BITS;
   localparam int DHI_START = FRAME_CYC - DHI_BYTES * BYTE_BITS;
   localparam int B1_END    = DHI_START - MID_GAP;
   localparam int B1_START  = B1_END - DLO_BYTES * BYTE_BITS;
   localparam int MAX_BYTES = (ALL_BYTES > DLO_BYTES + DHI_BYTES) ? ALL_BYTES
                                                                  : DLO_BYTES + DHI_BYTES;

   if (ALL_START < 1) begin : g_bad_all
      $error("overhead burst does not leave a gap");
   end
   if (B1_START < 1) begin : g_bad_dual
      $error("dual burst layout does not fit the frame");
   end
   if (BYTE_BITS < 2) begin : g_bad_bits
      $error("byte width must be at least 2");
   end
   if ((1 << IDX_W) <= MAX_BYTES) begin : g_bad_idx
      $error("index width too small for byte count");
   end

   ohb_mode_e        mode;
   logic [CYC_W-1:0] cyc_nxt, cyc_q;
   logic             ph_nxt, act, ck_q;

   assign mode = ohb_mode_e'(mode_i);

   ohb_frame_timer #(.FRAME_CYC(FRAME_CYC), .CYC_W(CYC_W)) u_timer (
      .clk       (clk),
      .rst_n     (rst_n),
      .fs_i      (fs_i),
      .cyc_nxt_o (cyc_nxt),
      .ph_nxt_o  (ph_nxt),
      .cyc_o     (cyc_q)
   );

   ohb_burst_window #(
      .CYC_W(CYC_W), .ALL_START(ALL_START), .DLO_START(DLO_START),
      .DHI_START(DHI_START), .B1_START(B1_START), .B1_END(B1_END)
   ) u_window (
      .mode_i (mode),
      .cyc_i  (cyc_nxt),
      .act_o  (act)
   );

   ohb_bit_shifter #(.BYTE_BITS(BYTE_BITS), .IDX_W(IDX_W), .MSB_FIRST(MSB_FIRST)) u_shift (
      .clk        (clk),
      .rst_n      (rst_n),
      .fall_i     (!ph_nxt),
      .rise_i     (ph_nxt),
      .act_i      (act),
      .clr_i      (!ph_nxt && cyc_nxt == '0),
      .tx_byte_i  (tx_byte_i),
      .rx_i       (rx_i),
      .tx_o       (tx_o),
      .tx_idx_o   (tx_idx_o),
      .rx_byte_o  (rx_byte_o),
      .byte_vld_o (byte_vld_o),
      .byte_idx_o (byte_idx_o)
   );

   // registered gated clock: high only in the second half of a clocked cycle
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ck_q <= 1'b0;
      else        ck_q <= ph_nxt && act;
   end

   assign sck_o = ck_q;

   int mode_bytes;
   always_comb begin
      unique case (mode)
         OHB_ALL:  mode_bytes = ALL_BYTES;
         OHB_DLO:  mode_bytes = DLO_BYTES;
         OHB_DHI:  mode_bytes = DHI_BYTES;
         default:  mode_bytes = DLO_BYTES + DHI_BYTES;
      endcase
   end

   a_r6_ck_half: assert property (@(posedge clk) disable iff (!rst_n)
      ck_q |=> !ck_q);
   a_r5_mid_gap: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == OHB_DALL && cyc_q >= CYC_W'(B1_END) && cyc_q < CYC_W'(DHI_START)) |-> !ck_q);
   a_r2_lead_gap: assert property (@(posedge clk) disable iff (!rst_n)
      (cyc_q < CYC_W'(ALL_START)) |-> !ck_q);
   a_r8_idx_range: assert property (@(posedge clk) disable iff (!rst_n)
      byte_vld_o |-> (int'(byte_idx_o) < mode_bytes));
endmodule

// File: tb/ohb_serial_gate_bench.sv
module ohb_serial_gate_bench;
   timeunit 1ns;
   timeprecision 100ps;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       fs_i = 1'b0;
   logic [1:0] mode_i = 2'b00;
   logic [7:0] tx_byte_i;
   logic       rx_i;
   logic       sck_o, tx_o, byte_vld_o;
   logic [4:0] tx_idx_o, byte_idx_o;
   logic [7:0] rx_byte_o;

   int total = 0;
   int bad = 0;
   bit done = 0;

   always #2.5 clk = ~clk;

   function automatic logic [7:0] txpat(input logic [1:0] m, input int k);
      return 8'((k * 29) ^ 8'h3C ^ (int'(m) * 8'h41));
   endfunction
   function automatic logic [7:0] rxpat(input logic [1:0] m, input int k);
      return 8'(8'hC5 + k * 53 + int'(m) * 8'h1B);
   endfunction
   function automatic bit bact(input logic [1:0] m, input int c);
      case (m)
         2'b00:   return c >= 27;
         2'b01:   return c >= 219;
         2'b10:   return c >= 171;
         default: return (c >= 99 && c < 123) || c >= 171;
      endcase
   endfunction
   function automatic int pulses(input logic [1:0] m);
      case (m)
         2'b00: return 216;
         2'b01: return 24;
         2'b10: return 72;
         default: return 96;
      endcase
   endfunction
   function automatic int first_t(input logic [1:0] m);
      case (m)
         2'b00: return 55;
         2'b01: return 439;
         2'b10: return 343;
         default: return 199;
      endcase
   endfunction
   function automatic string mtag(input logic [1:0] m);
      case (m)
         2'b00: return "R2";
         2'b01: return "R3";
         2'b10: return "R4";
         default: return "R5";
      endcase
   endfunction

   task automatic chk(input bit ok, input string tag, input string what, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
      end
   endtask

   // bench counters driven from the bench's own frame model
   int t = 0;
   int rk = 0;
   int tk = 0;
   assign tx_byte_i = txpat(mode_i, int'(tx_idx_o));
   assign rx_i = rxpat(mode_i, rk / 8)[7 - (rk % 8)];

   ohb_serial_gate u_ohb_serial_gate (
      .clk(clk), .rst_n(rst_n), .fs_i(fs_i), .mode_i(mode_i),
      .tx_byte_i(tx_byte_i), .rx_i(rx_i), .sck_o(sck_o), .tx_o(tx_o),
      .tx_idx_o(tx_idx_o), .rx_byte_o(rx_byte_o), .byte_vld_o(byte_vld_o),
      .byte_idx_o(byte_idx_o)
   );

   always @(posedge clk) begin
      if (!rst_n || fs_i) t <= 0;
      else                t <= t + 1;
   end

   // scoreboard
   logic [15:0] exp_q[$];
   int   rises, first_rise, shape_err;
   bit   cut = 0, cur_by_fs = 0, have_frame = 0, rchk_done = 0;
   logic [1:0] cur_mode;
   logic ck_prev, tx_prev;
   logic [7:0] tacc;

   task automatic frame_summary();
      chk(shape_err == 0, {mtag(cur_mode), "/R6"}, "clock shape mismatches", shape_err, 0);
      if (!cut)
         chk(rises == pulses(cur_mode), mtag(cur_mode), "pulses per frame", rises, pulses(cur_mode));
      if (!cut || first_rise >= 0)
         chk(first_rise == first_t(cur_mode), cur_by_fs ? "R9" : "R1",
             "first rise offset", first_rise, first_t(cur_mode));
   endtask

   always @(negedge clk) begin
      int fpos;
      bit exp_ck;
      logic [15:0] item;
      if (done) begin
      end else if (!rst_n) begin
         if (!rchk_done) begin
            rchk_done = 1;
            chk(sck_o == 0 && tx_o == 0 && byte_vld_o == 0 && tx_idx_o == 0 && byte_idx_o == 0,
                "R10", "reset outputs", int'({sck_o, tx_o, byte_vld_o, tx_idx_o, byte_idx_o}), 0);
         end
         rises = 0; first_rise = -1; shape_err = 0; tk = 0; rk = 0;
         cur_by_fs = 0; cut = 0; cur_mode = mode_i; have_frame = 1;
         ck_prev = 0; tx_prev = 0;
      end else begin
         fpos = t % 486;
         if (fpos == 0) begin
            if (have_frame) frame_summary();
            rises = 0; first_rise = -1; shape_err = 0; tk = 0; rk = 0;
            cur_by_fs = cut; cut = 0; cur_mode = mode_i; have_frame = 1;
            chk(tx_idx_o == 0, cur_by_fs ? "R9" : "R7", "slot index at frame start", int'(tx_idx_o), 0);
         end
         exp_ck = (fpos % 2 == 1) && bact(mode_i, (fpos - 1) / 2);
         if (sck_o !== exp_ck) shape_err++;
         if (sck_o && tx_o !== tx_prev) shape_err++;
         if (sck_o && !ck_prev) begin
            rises++;
            if (first_rise < 0) first_rise = fpos;
            tacc = {tacc[6:0], tx_o};
            tk++;
            if (tk % 8 == 0)
               chk(tacc == txpat(mode_i, tk / 8 - 1), "R7", "transmit byte",
                   int'(tacc), int'(txpat(mode_i, tk / 8 - 1)));
            if (rk % 8 == 7)
               exp_q.push_back({8'(rk / 8), rxpat(mode_i, rk / 8)});
            rk++;
         end
         if (byte_vld_o) begin
            if (exp_q.size() == 0) begin
               chk(0, "R8", "unexpected byte strobe", int'(byte_idx_o), -1);
            end else begin
               item = exp_q.pop_front();
               chk(rx_byte_o == item[7:0] && byte_idx_o == item[12:8], "R8", "received byte/index",
                   int'({3'b0, byte_idx_o, rx_byte_o}), int'(item));
            end
         end
         ck_prev = sck_o;
         tx_prev = tx_o;
      end
   end

   task automatic pulse_fs(input logic [1:0] m);
      @(negedge clk);
      #1 mode_i = m; fs_i = 1'b1; cut = 1;
      @(negedge clk);
      #1 fs_i = 1'b0;
   endtask

   initial begin
      repeat (10) @(negedge clk);
      #1 rst_n = 1'b1;
      repeat (486 * 2 + 20) @(posedge clk);
      pulse_fs(2'b01);
      repeat (486 * 2 + 20) @(posedge clk);
      pulse_fs(2'b10);
      repeat (486 * 2 + 20) @(posedge clk);
      pulse_fs(2'b11);
      repeat (486 * 2 + 400) @(posedge clk);
      pulse_fs(2'b11);
      repeat (486 * 2 + 200) @(posedge clk);
      pulse_fs(2'b00);
      repeat (486 * 2 + 10) @(posedge clk);
      @(negedge clk);
      #1;
      chk(exp_q.size() == 0, "R8", "bytes left unreported", exp_q.size(), 0);
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      #(5ns * 150000);
      if (!done) begin
         done = 1;
         total++;
         bad++;
         $display("FAIL watchdog R1 actual=%0d expected=%0d", 1, 0);
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule